// File: doc/BRIEF.md
# Dual Signed Halfword Multiply-Accumulate

This block is the arithmetic core of a dual 16-bit signed multiply-accumulate operation. Each operand word holds two signed halfwords. The block forms two halfword products, pairing the low halves with each other and the high halves with each other. A swap control exchanges the halfwords of the second operand first, so the pairing becomes crossed. The two products are then added, or the high product is subtracted from the low product. When accumulation is enabled, a 32-bit signed accumulator is added as well.

The result is registered when the valid strobe is high. It is the low 32 bits of the exact sum and wraps instead of saturating. A sticky overflow flag records any result whose exact value does not fit in 32 signed bits. The flag is judged once on the exact three-term sum, which is held at wider precision. It is not built up from two chained 32-bit overflow tests. As a result, a large intermediate that comes back into range does not set the flag. A synchronous clear input resets the flag.

Top module: `dual_mac16`

## Requirements
- R1: Without swap, the low halfword of `op_a_i` is multiplied by the low halfword of `op_b_i`, and the high halfword by the high halfword. All four halfwords are treated as two's-complement signed, and in add mode the result is the sum of the two products.
- R2: With `swap_i` = 1, the halfwords of `op_b_i` are exchanged first. The low half of A is then multiplied by the high half of B, and the high half of A by the low half of B.
- R3: With `sub_i` = 1, the result is the low-pair product minus the high-pair product, where the pairs are taken after any swap.
- R4: With `acc_en_i` = 1, the signed `acc_i` is added to the combined products. With `acc_en_i` = 0, `acc_i` has no effect on the result or on the flag.
- R5: `result_o` is bits [31:0] of the exact sum and wraps without saturation. For example, two products of 2^30 give 0x80000000.
- R6: On a valid cycle, `q_o` is set exactly when the exact sum lies outside [-2^31, 2^31-1]. A subtraction without accumulation therefore never sets it.
- R7: The case (-32768 x -32768) + (-32768 x -32768) + (-1) with accumulation gives 0x7FFFFFFF and does not set `q_o`.
- R8: Once `q_o` is set, it stays set through later valid cycles that do not overflow, as long as `q_clr_i` is low.
- R9: `q_clr_i` = 1 drives `q_o` to 0 on the next edge. An overflow in the same cycle takes priority and leaves `q_o` at 1.
- R10: While `valid_i` = 0, `result_o` and `q_o` hold their values, apart from a clear through `q_clr_i`.
- R11: After reset (`rst_n` low), `result_o` is 0 and `q_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Qualifies the operation; loads the result and allows the flag to be set |
| swap_i | input | 1 | Exchange the halfwords of op_b_i before multiplying |
| sub_i | input | 1 | Subtract the high-pair product instead of adding it |
| acc_en_i | input | 1 | Add acc_i to the products |
| op_a_i | input | 32 | First operand, two signed halfwords |
| op_b_i | input | 32 | Second operand, two signed halfwords |
| acc_i | input | 32 | Signed accumulator term |
| q_clr_i | input | 1 | Synchronous clear of the overflow flag |
| result_o | output | 32 | Registered wrapped result |
| q_o | output | 1 | Sticky overflow flag |

## Verification
The embedded properties assume that `valid_i`, `q_clr_i` and the mode bits are known (0 or 1) at every clock edge after reset. They also assume that the flag changes only through a valid cycle or a clear. The bench drives every control bit at the falling edge and never leaves one undefined. It sweeps six edge halfword values (the most negative, the most negative plus one, -1, 0, 1 and the most positive) into all four halfword positions. Each combination is run under every swap, subtract and accumulate setting and against four accumulator extremes. The clear input is raised on each sweep vector, so the flag shows that vector's overflow alone. Directed sequences then cover stickiness, clear priority and the hold behaviour.

// File: rtl/dual_mac16.sv
module dual_mac16 #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic            swap_i,
  input  logic            sub_i,
  input  logic            acc_en_i,
  input  logic [2*HW-1:0] op_a_i,
  input  logic [2*HW-1:0] op_b_i,
  input  logic [2*HW-1:0] acc_i,
  input  logic            q_clr_i,
  output logic [2*HW-1:0] result_o,
  output logic            q_o
);
  localparam int W  = 2 * HW;
  localparam int SW = W + 2;

  logic signed [HW-1:0] a_lo, a_hi, b_lo, b_hi;
  logic signed [W-1:0]  p_lo, p_hi;
  logic signed [SW-1:0] e_lo, e_hi, e_acc, sum;
  logic                 ovf;

  assign a_lo = op_a_i[HW-1:0];
  assign a_hi = op_a_i[W-1:HW];
  assign b_lo = swap_i ? op_b_i[W-1:HW] : op_b_i[HW-1:0];
  assign b_hi = swap_i ? op_b_i[HW-1:0] : op_b_i[W-1:HW];

  assign p_lo = W'(a_lo) * W'(b_lo);
  assign p_hi = W'(a_hi) * W'(b_hi);

  assign e_lo  = {{(SW-W){p_lo[W-1]}}, p_lo};
  assign e_hi  = {{(SW-W){p_hi[W-1]}}, p_hi};
  assign e_acc = acc_en_i ? {{(SW-W){acc_i[W-1]}}, acc_i} : '0;

  assign sum = e_lo + (sub_i ? -e_hi : e_hi) + e_acc;

  // overflow when the bits above the result are not all copies of its sign
  assign ovf = (|sum[SW-1:W-1]) & ~(&sum[SW-1:W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      q_o      <= 1'b0;
    end else begin
      if (valid_i) result_o <= sum[W-1:0];
      q_o <= (q_o & ~q_clr_i) | (valid_i & ovf);
    end
  end

  assert_q_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !q_clr_i) |=> q_o);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clr_i && !valid_i) |=> !q_o);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o));

  assert_sub_no_q_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sub_i && !acc_en_i && q_clr_i) |=> !q_o);

  assert_q_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(valid_i));

  assert_noacc_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !acc_en_i && !sub_i && q_clr_i &&
     op_a_i[HW-1:0] == '0 && op_a_i[W-1:HW] == '0) |=> (result_o == '0 && !q_o));
endmodule

// File: tb/dual_mac16_bench.sv
`timescale 1ns/1ps
module dual_mac16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, swap_i = 1'b0, sub_i = 1'b0, acc_en_i = 1'b0, q_clr_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0, acc_i = '0;
  logic [31:0] result_o;
  logic        q_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dual_mac16 u_dual_mac16 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .swap_i(swap_i), .sub_i(sub_i),
    .acc_en_i(acc_en_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_i(acc_i),
    .q_clr_i(q_clr_i), .result_o(result_o), .q_o(q_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] c, input logic sw,
                                   input logic sb, input logic ae);
    longint al, ah, bl, bh, s;
    al = longint'($signed(a[15:0]));
    ah = longint'($signed(a[31:16]));
    bl = longint'($signed(sw ? b[31:16] : b[15:0]));
    bh = longint'($signed(sw ? b[15:0] : b[31:16]));
    s  = sb ? (al * bl - ah * bh) : (al * bl + ah * bh);
    if (ae) s += longint'($signed(c));
    return s;
  endfunction

  function automatic logic out_of_range(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic drive(input logic v, input logic sw, input logic sb, input logic ae,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic clr);
    valid_i = v; swap_i = sw; sub_i = sb; acc_en_i = ae;
    op_a_i = a; op_b_i = b; acc_i = c; q_clr_i = clr;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] hv [6];
    logic [31:0] av [4];
    hv = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF};
    av = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};

    repeat (3) @(negedge clk);
    check("R11 result", result_o, 32'h0);
    check("R11 q", {31'b0, q_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: two products of 2^30 wrap to 0x80000000, overflow (R6)
    drive(1, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h0, 0);
    check("R5 wrap", result_o, 32'h8000_0000);
    check("R6 add overflow", {31'b0, q_o}, 32'h1);

    // R8: non-overflowing op keeps Q set
    drive(1, 0, 0, 0, 32'h0001_0001, 32'h0001_0001, 32'h0, 0);
    check("R8 result", result_o, 32'h2);
    check("R8 sticky", {31'b0, q_o}, 32'h1);

    // R9: clear alone
    drive(0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 1);
    check("R9 clear", {31'b0, q_o}, 32'h0);

    // R7: corner case does not set Q
    drive(1, 0, 0, 1, 32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 0);
    check("R7 result", result_o, 32'h7FFF_FFFF);
    check("R7 q", {31'b0, q_o}, 32'h0);

    // R4: accumulator ignored when disabled
    drive(1, 0, 0, 0, 32'h0002_0003, 32'h0005_0007, 32'h1234_5678, 0);
    check("R4 ignored acc", result_o, 32'd31);
    drive(1, 0, 0, 1, 32'h0002_0003, 32'h0005_0007, 32'h0000_0064, 0);
    check("R4 acc added", result_o, 32'd131);

    // R6: extreme subtract without accumulation never sets Q
    drive(1, 0, 1, 0, 32'h8000_8000, 32'h7FFF_8000, 32'h0, 0);
    check("R6 sub no q", {31'b0, q_o}, 32'h0);
    check("R3 sub result", result_o, 32'h7FFF_8000);

    // R9: overflow in same cycle as clear wins
    drive(1, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h0, 1);
    check("R9 set beats clear", {31'b0, q_o}, 32'h1);

    // R10: no valid -> hold
    drive(0, 1, 1, 1, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1, 0);
    check("R10 hold result", result_o, 32'h8000_0000);
    check("R10 hold q", {31'b0, q_o}, 32'h1);

    // R2 directed: swap pairs crossed halves
    drive(1, 1, 0, 0, 32'h0002_0003, 32'h0005_0007, 32'h0, 1);
    check("R2 swap", result_o, 32'd29);

    // sweep over edge halfwords, all modes, accumulator extremes
    for (int ah = 0; ah < 6; ah++)
      for (int al = 0; al < 6; al++)
        for (int bh = 0; bh < 6; bh++)
          for (int bl = 0; bl < 6; bl++)
            for (int m = 0; m < 8; m++)
              for (int k = 0; k < 4; k++) begin
                logic [31:0] a, b;
                longint s;
                string rq;
                a = {hv[ah], hv[al]};
                b = {hv[bh], hv[bl]};
                s = model(a, b, av[k], m[0], m[1], m[2]);
                drive(1, m[0], m[1], m[2], a, b, av[k], 1);
                rq = m[2] ? "R4 sweep" : (m[1] ? "R3 sweep" : (m[0] ? "R2 sweep" : "R1 sweep"));
                check(rq, result_o, s[31:0]);
                check("R6 sweep q", {31'b0, q_o}, {31'b0, out_of_range(s)});
              end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule